// File: doc/BRIEF.md
# Microprocessor Supervisor with Watchdog

This block is the clocked decision core of a processor supervisor. It receives a supply-good flag that an external comparator has already synchronised, and a watchdog line that analog front-end logic has already resolved into low, high or mid-level. From these it drives an active-low processor reset, its active-high complement, and an active-low watchdog status flag.

Reset is held for as long as the supply is bad. It is then stretched for a fixed number of clock cycles after the supply recovers. Software keeps the watchdog alive by moving the watchdog line between low and high. Either direction counts as service. If the line stays at one logic level for the full timeout, a reset pulse of the stretch length is issued and the status flag drops. While the line stays stuck, further pulses follow, one per timeout window.

A mid-level or floating line turns the watchdog off. Both durations are parameters in clock cycles. The defaults match 200 ms and 1.6 s at 125 MHz. A bench can use short values.

Top module: `msup_core`

## Requirements
- R1: From the first clock edge at which `supply_ok` is sampled low, `rst_out_n` is low, and it stays low while `supply_ok` remains low.
- R2: `rst_out_n` returns high after the HOLD_CYC-th consecutive clock edge at which `supply_ok` is sampled high. This applies both after a supply fault and after the synchronous reset `rst_n` is released.
- R3: `wd_level` is encoded as 2'b00 = low, 2'b01 = high, 2'b10 or 2'b11 = mid. If the line is at low or high and no service edge, fault or reset pulse occurs for TMO_CYC counting edges, the TMO_CYC-th edge starts a reset pulse. `rst_out_n` is then low for HOLD_CYC cycles, and `wd_stat_n` goes low.
- R4: A change from low to high, or from high to low, between two consecutive sampled values is a service edge. It restarts the timeout count from zero.
- R5: While the line stays stuck at one logic level, reset pulses repeat with a period of HOLD_CYC + TMO_CYC cycles. The count is held during each pulse and restarts when the pulse ends.
- R6: `wd_stat_n` returns high at the clock edge that samples the next service edge, even while a reset pulse is still running.
- R7: While `supply_ok` is low, `wd_stat_n` is forced high and the watchdog count is held at zero. After recovery, the first timeout therefore occurs TMO_CYC edges after reset releases.
- R8: At mid-level the watchdog is disabled: no timeout pulse is issued and `wd_stat_n` is high. Moving into or out of mid-level is not a service edge. Leaving mid-level starts the count from zero.
- R9: `rst_out` is always the exact complement of `rst_out_n`.
- R10: While `rst_n` is sampled low, the block sets `rst_out_n` low and `wd_stat_n` high, and clears the watchdog count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Synchronised supply-good flag from the comparator |
| wd_level | input | 2 | Decoded watchdog line: 00 low, 01 high, 1x mid |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |
| wd_stat_n | output | 1 | Active-low watchdog timeout status |

## Verification
The watchdog line is driven in four patterns, each checked against a behavioural model cycle by cycle:
- **Regular toggling within the window.** This separates service from timeout.
- **A line stuck at one level.** This exposes the pulse-train period and shows whether the count is held during each pulse.
- **Brief visits to mid-level between low and high.** This shows whether level changes through mid are wrongly accepted as service, and whether the count restarts on leaving mid.
- **A supply fault raised while the status flag is low.** This separates the supply path from the watchdog path: status must be forced high, and the timeout must be measured again from release.

// File: rtl/msup_pkg.sv
// Package: shared types for the supervisor core.
// Assumes the watchdog line arrives already resolved to a two-bit code.
package msup_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_MID  = 2'b10
    } lvl_e;

    // Map the two-bit line code to a level; both codes with bit 1 set mean mid.
    function automatic lvl_e decode_level(input logic [1:0] code);
        if (code[1]) begin
            return LVL_MID;
        end
        return code[0] ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/msup_level_track.sv
// Module: msup_level_track
// Classifies the decoded watchdog line and flags service edges.
// A service edge is a low<->high change between two consecutive samples;
// any step into or out of mid-level is not service.
// Assumes wd_level is synchronous to clk.
module msup_level_track
    import msup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] wd_level,
    output logic       svc_edge,
    output logic       is_mid
);

    lvl_e cur_lvl;
    lvl_e prev_lvl;

    // Decode the present sample.
    assign cur_lvl = decode_level(wd_level);

    // Remember the previous sample; reset to mid so release never looks like service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= LVL_MID;
        end else begin
            prev_lvl <= cur_lvl;
        end
    end

    // Report mid-level and service edges.
    assign is_mid   = (cur_lvl == LVL_MID);
    assign svc_edge = (cur_lvl != LVL_MID) && (prev_lvl != LVL_MID) && (cur_lvl != prev_lvl);

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_edge |-> (wd_level != $past(wd_level)))
        else $error("service edge without line change"); // R4

endmodule

// File: rtl/msup_wd_timer.sv
// Module: msup_wd_timer
// Counts cycles of watchdog inactivity and raises a one-cycle timeout.
// Also keeps the active-low status flag.
// The count is held at zero during a fault, a running reset pulse,
// mid-level, or a service edge.
// Assumes TMO_CYC >= 1.
module msup_wd_timer #(
    parameter int unsigned TMO_CYC = 200_000_000,
    localparam int unsigned CW     = $clog2(TMO_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic busy,
    input  logic is_mid,
    input  logic svc_edge,
    output logic timeout,
    output logic stat_n
);

    logic [CW-1:0] idle_cnt;
    logic          count_en;
    logic          stat_q;

    // Counting is allowed only when nothing holds or restarts the timer.
    assign count_en = !(fault || busy || is_mid || svc_edge);
    assign timeout  = count_en && (idle_cnt == CW'(TMO_CYC - 1));

    // Inactivity counter; it wraps to zero on timeout to start the next window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!count_en || timeout) begin
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Status flag: dropped by timeout, raised by fault, mid-level or service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b1;
        end else if (fault || is_mid || svc_edge) begin
            stat_q <= 1'b1;
        end else if (timeout) begin
            stat_q <= 1'b0;
        end
    end

    assign stat_n = stat_q;

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idle_cnt) < TMO_CYC)
        else $error("idle count overflow"); // R3
    AST_FAULT_STAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> stat_n)
        else $error("status low after fault"); // R7
    AST_MID_STAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        is_mid |=> stat_n)
        else $error("status low at mid-level"); // R8
    AST_EDGE_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        svc_edge |=> (idle_cnt == '0))
        else $error("service edge did not restart count"); // R4
    AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (idle_cnt == '0))
        else $error("count advanced during reset"); // R5

endmodule

// File: rtl/msup_rst_stretch.sv
// Module: msup_rst_stretch
// Holds a down-counter that keeps the processor reset asserted.
// A supply fault or a watchdog timeout loads HOLD_CYC; otherwise the counter
// runs down to zero, and reset is active while the counter is non-zero.
// Assumes HOLD_CYC >= 1.
module msup_rst_stretch #(
    parameter int unsigned HOLD_CYC = 25_000_000,
    localparam int unsigned HW      = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic trigger,
    output logic busy
);

    logic [HW-1:0] hold_cnt;

    // Load on fault or timeout, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= HW'(HOLD_CYC);
        end else if (fault || trigger) begin
            hold_cnt <= HW'(HOLD_CYC);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // Reset is requested while time remains.
    assign busy = (hold_cnt != '0);

    AST_FAULT_ASSERTS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> busy)
        else $error("reset not held during fault"); // R1
    AST_TRIG_ASSERTS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> busy)
        else $error("timeout gave no reset"); // R3
    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(fault))
        else $error("reset released during fault"); // R2

endmodule

// File: rtl/msup_core.sv
// Module: msup_core (top)
// Supervisor control core: supply-fault reset stretching plus a watchdog
// that has a three-level input and produces a repeating pulse train.
// Assumes supply_ok and wd_level are already synchronous to clk.
// Durations are in clock cycles.
module msup_core #(
    parameter int unsigned HOLD_CYC = 25_000_000,
    parameter int unsigned TMO_CYC  = 200_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic [1:0] wd_level,
    output logic       rst_out_n,
    output logic       rst_out,
    output logic       wd_stat_n
);

    logic fault;
    logic svc_edge;
    logic is_mid;
    logic timeout;
    logic busy;

    // A fault is simply a low supply-good flag.
    assign fault = !supply_ok;

    msup_level_track u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .wd_level (wd_level),
        .svc_edge (svc_edge),
        .is_mid   (is_mid)
    );

    msup_wd_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (fault),
        .busy     (busy),
        .is_mid   (is_mid),
        .svc_edge (svc_edge),
        .timeout  (timeout),
        .stat_n   (wd_stat_n)
    );

    msup_rst_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault   (fault),
        .trigger (timeout),
        .busy    (busy)
    );

    // Drive both reset polarities from the same stretch state.
    assign rst_out_n = !busy;
    assign rst_out   = busy;

    AST_TMO_DROPS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (!wd_stat_n && !rst_out_n))
        else $error("timeout not reflected at outputs"); // R3
    AST_MID_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mid && !busy && supply_ok) |=> rst_out_n)
        else $error("pulse issued at mid-level"); // R8

endmodule

// File: tb/msup_core_tb_top.sv
// Bench: a behavioural reference model compared with the outputs every
// cycle, plus directed checks at the boundaries.
module msup_core_tb_top;

    localparam int HOLD = 5;
    localparam int TMO  = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic [1:0] wd_level = 2'b10;
    logic       rst_out_n;
    logic       rst_out;
    logic       wd_stat_n;

    always #4 clk = ~clk;

    msup_core #(.HOLD_CYC(HOLD), .TMO_CYC(TMO)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .wd_level  (wd_level),
        .rst_out_n (rst_out_n),
        .rst_out   (rst_out),
        .wd_stat_n (wd_stat_n)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    task automatic chk(input string req, input int act, input int exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // Reference model: remaining reset cycles, idle cycles, last level, status.
    int m_rem = HOLD;
    int m_idle = 0;
    int m_prev = 2;
    int m_stat = 1;
    bit m_valid = 1'b0;

    always @(posedge clk) begin : ref_model
        int lv;
        bit edg;
        bit flt;
        bit tmo;
        bit was_busy;
        lv = wd_level[1] ? 2 : int'(wd_level[0]);
        if (!rst_n) begin
            m_rem = HOLD; m_idle = 0; m_prev = 2; m_stat = 1; m_valid = 1'b1;
        end else begin
            edg      = (lv != 2) && (m_prev != 2) && (lv != m_prev);
            flt      = !supply_ok;
            was_busy = (m_rem > 0);
            tmo      = 1'b0;
            if (flt || lv == 2 || edg || was_busy) begin
                m_idle = 0;
            end else if (m_idle + 1 == TMO) begin
                tmo = 1'b1;
                m_idle = 0;
            end else begin
                m_idle++;
            end
            if (flt || tmo) m_rem = HOLD;
            else if (m_rem > 0) m_rem--;
            if (flt || lv == 2 || edg) m_stat = 1;
            else if (tmo) m_stat = 0;
            m_prev = lv;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk({cur_req, " rst_out_n"}, int'(rst_out_n), (m_rem == 0) ? 1 : 0);
            chk({cur_req, " wd_stat_n"}, int'(wd_stat_n), m_stat);
            chk("R9 complement", int'(rst_out), int'(!rst_out_n));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin : stim
        int pulses;
        logic prev_r;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 rst_out_n", int'(rst_out_n), 0);
        chk("R10 wd_stat_n", int'(wd_stat_n), 1);

        // R2 release latency after rst_n
        cur_req = "R2";
        supply_ok = 1'b1;
        rst_n = 1'b1;
        repeat (HOLD - 1) @(negedge clk);
        chk("R2 still held", int'(rst_out_n), 0);
        @(negedge clk);
        chk("R2 released", int'(rst_out_n), 1);

        // R8 mid-level disables
        cur_req = "R8";
        repeat (3 * TMO) @(negedge clk);
        chk("R8 no pulse at mid", int'(rst_out_n), 1);
        wd_level = 2'b00;
        repeat (TMO - 2) @(negedge clk);
        wd_level = 2'b11;
        repeat (3) @(negedge clk);
        wd_level = 2'b01;
        repeat (TMO - 1) @(negedge clk);
        chk("R8 count restarted", int'(rst_out_n), 1);
        @(negedge clk);
        chk("R3 timeout pulse", int'(rst_out_n), 0);
        chk("R3 status low", int'(wd_stat_n), 0);

        // R6 service clears status during pulse
        cur_req = "R6";
        wd_level = 2'b00;
        @(negedge clk);
        chk("R6 status raised", int'(wd_stat_n), 1);
        chk("R6 pulse continues", int'(rst_out_n), 0);

        // R4 regular toggling keeps reset away
        cur_req = "R4";
        for (int i = 0; i < 10; i++) begin
            repeat (7) @(negedge clk);
            wd_level = {1'b0, ~wd_level[0]};
        end
        repeat (TMO - 1) @(negedge clk);
        chk("R4 serviced, no pulse", int'(rst_out_n), 1);

        // R5 pulse train while stuck
        cur_req = "R5";
        wd_level = {1'b0, ~wd_level[0]};
        pulses = 0;
        prev_r = rst_out_n;
        repeat (TMO + 2 * (HOLD + TMO) + 2) begin
            @(negedge clk);
            if (prev_r && !rst_out_n) pulses++;
            prev_r = rst_out_n;
        end
        chk("R5 pulse count", pulses, 3);
        chk("R5 status low", int'(wd_stat_n), 0);

        // R7/R1 supply fault
        cur_req = "R1";
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R7 status forced high", int'(wd_stat_n), 1);
        chk("R1 reset on fault", int'(rst_out_n), 0);
        repeat (3 * TMO) @(negedge clk);
        chk("R1 held during fault", int'(rst_out_n), 0);
        cur_req = "R7";
        supply_ok = 1'b1;
        repeat (HOLD) @(negedge clk);
        chk("R2 release after fault", int'(rst_out_n), 1);
        repeat (TMO - 1) @(negedge clk);
        chk("R7 count fresh after fault", int'(rst_out_n), 1);
        @(negedge clk);
        chk("R7 first timeout", int'(rst_out_n), 0);

        // R8 final mid stretch
        cur_req = "R8";
        wd_level = 2'b10;
        repeat (HOLD + 3 * TMO) @(negedge clk);
        chk("R8 disabled long", int'(rst_out_n), 1);
        chk("R8 status high", int'(wd_stat_n), 1);

        finish_run();
    end

endmodule